// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block runs one I2C message from start to finish in hardware. It reacts to the status codes of a byte-level I2C master controller and writes that controller's data and control registers. The block does not time the bus itself: the controller raises an event with a status code whenever it needs attention, and the sequencer answers with at most one data-register write followed by one control-register write.

A message is launched with a one-cycle `go` pulse. The descriptor holds a 7- or 10-bit target address, a read flag, a flag that inverts the direction bit, a flag that skips the start and address phases, and a byte count. Write bytes come from a byte source that advances on `tx_take`. Read bytes appear on `rx_byte` with a `rx_valid` strobe. When the message ends, a one-cycle `done` pulse carries a result code.

A cycle timeout guards every message. When the first window expires, the message is told to abort after the byte in flight. When a second window expires, the block gives the bus up as locked. An external abort request starts the same wind-down.

Top module: `i2c_msg_seq`

## Requirements
- R1: For a 7-bit message, the first address byte is {addr[6:0], dir}. dir is 1 for a read, and it is inverted when the reverse-direction flag is set.
- R2: For a 10-bit message, the first address byte is {5'b11110, addr[9:8], dir}. When status 0x18 or 0x40 arrives, the second address byte addr[7:0] is sent.
- R3: After reset no output is active. A `go` without the no-start flag issues a control write with START (bit 5) set. Status 0x08 or 0x10 is answered with the first address byte.
- R4: Each write acknowledge (0x18 for a 7-bit message, 0xD0, 0x28) is answered with the next source byte while bytes remain. Otherwise the block sends a stop and completes with result 0 (ok).
- R5: A read address acknowledge (0x40 for a 7-bit message, 0xE0) with zero length is answered with a stop. Otherwise it is answered with a control-only write. Status 0x50 delivers `ev_rx_byte` on `rx_byte` and decrements the remaining count.
- R6: When one byte remains, ACK (bit 2) is cleared in this and every later control write, so that the last byte is not acknowledged. Status 0x58 delivers the byte, sends a stop and completes.
- R7: Status 0x20, 0x30 or 0x48 sends a stop and completes with result 1 (no device).
- R8: Any status that is not recognised sends a stop and completes with result 2 (I/O error).
- R9: Every control write has the enable bit (bit 6) set. The first control write of a message also has interrupt-enable (bit 7) and ACK set. A stop write sets STOP (bit 4) and clears interrupt-enable. A data write is always followed in the next cycle by the control write of the same action. The first command appears one cycle after the event.
- R10: With the no-start flag set, a read begins with a control-only write. A write begins at once with its first data byte, then its control write.
- R11: A status event that arrives while no message is active is answered with a stop write and no `done`.
- R12: When `tmo_cycles` cycles pass without completion, or when `abort_req` is raised, an abort becomes pending. After the abort, a write stops at its next acknowledge once at least one data byte has gone out. A read clears ACK on its next control write. A timeout abort completes with result 3.
- R13: If a second `tmo_cycles` window also expires, the block returns to idle and pulses `done` with result 3, with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Launch the described message (ignored while busy) |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit addressing |
| msg_rd | input | 1 | Read message |
| msg_rev | input | 1 | Invert the direction bit |
| msg_nostart | input | 1 | Skip the start and address phases |
| msg_len | input | LEN_W | Byte count |
| tmo_cycles | input | TMO_W | Timeout window in cycles (nonzero) |
| abort_req | input | 1 | Request a wind-down of the active message |
| ev_valid | input | 1 | Controller status event |
| ev_code | input | 8 | Status code of the event |
| ev_rx_byte | input | 8 | Controller data register value at the event |
| tx_byte | input | 8 | Current write byte from the source |
| tx_take | output | 1 | Source byte consumed this cycle |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| cmd_valid | output | 1 | Register write to the controller |
| cmd_ctrl | output | 1 | 1: control register, 0: data register |
| cmd_byte | output | 8 | Value written |
| done | output | 1 | Message complete |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 timeout |

## Verification
The bench plays the controller through several patterns, and each one separates paths that share status codes.
- A 7-bit write and a 10-bit write tell 0x18 apart as either a data acknowledge or a second-address request.
- A multi-byte read shows that ACK drops at exactly the last byte.
- Reverse-direction, zero-length read, no-device and stray-code runs exercise the error and empty exits.
- No-start reads and writes show the skipped phases.
- Two timeout runs tell the abort-after-byte wind-down apart from the forced bus-lock release, and an abort request on a read shows the early NACK.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADR1, ST_ADR2, ST_TXACK, ST_RXDAT
  } seq_st_e;

  localparam logic [7:0] CB_ACK   = 8'h04;
  localparam logic [7:0] CB_STOP  = 8'h10;
  localparam logic [7:0] CB_START = 8'h20;
  localparam logic [7:0] CB_EN    = 8'h40;
  localparam logic [7:0] CB_INTEN = 8'h80;
  localparam logic [7:0] CB_INIT  = CB_ACK | CB_INTEN | CB_EN;

  localparam logic [7:0] SC_START  = 8'h08;
  localparam logic [7:0] SC_RSTART = 8'h10;
  localparam logic [7:0] SC_WA_ACK = 8'h18;
  localparam logic [7:0] SC_WA_NAK = 8'h20;
  localparam logic [7:0] SC_WD_ACK = 8'h28;
  localparam logic [7:0] SC_WD_NAK = 8'h30;
  localparam logic [7:0] SC_RA_ACK = 8'h40;
  localparam logic [7:0] SC_RA_NAK = 8'h48;
  localparam logic [7:0] SC_RD_ACK = 8'h50;
  localparam logic [7:0] SC_RD_NAK = 8'h58;
  localparam logic [7:0] SC_WA2_ACK = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK = 8'hE0;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_NODEV = 2'd1;
  localparam logic [1:0] RES_IOERR = 2'd2;
  localparam logic [1:0] RES_TMO   = 2'd3;
endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  input  logic       rev,
  output logic [7:0] byte1,
  output logic [7:0] byte2
);
  logic dir;
  always_comb begin
    dir = rd ^ rev;
    if (ten) begin
      byte1 = {5'b11110, addr[9:8], dir};
      byte2 = addr[7:0];
    end else begin
      byte1 = {addr[6:0], dir};
      byte2 = 8'h00;
    end
  end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = restart || (run && cnt_q != limit);
    cnt_d  = restart ? '0 : cnt_q + W'(1);
    hit    = run && (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_seq_emit.sv
module i2c_seq_emit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic       has_data,
  input  logic [7:0] data_byte,
  input  logic [7:0] ctrl_byte,
  output logic       cmd_valid,
  output logic       cmd_ctrl,
  output logic [7:0] cmd_byte
);
  logic       pend_q, pend_d;
  logic [7:0] pbyte_q, pbyte_d;
  logic       v_d, c_d;
  logic [7:0] b_d;

  always_comb begin
    pend_d  = 1'b0;
    pbyte_d = pbyte_q;
    v_d     = 1'b0;
    c_d     = 1'b0;
    b_d     = 8'h00;
    if (issue) begin
      v_d = 1'b1;
      if (has_data) begin
        b_d     = data_byte;
        pend_d  = 1'b1;
        pbyte_d = ctrl_byte;
      end else begin
        c_d = 1'b1;
        b_d = ctrl_byte;
      end
    end else if (pend_q) begin
      v_d = 1'b1;
      c_d = 1'b1;
      b_d = pbyte_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pbyte_q   <= 8'h00;
      cmd_valid <= 1'b0;
      cmd_ctrl  <= 1'b0;
      cmd_byte  <= 8'h00;
    end else begin
      pend_q    <= pend_d;
      pbyte_q   <= pbyte_d;
      cmd_valid <= v_d;
      cmd_ctrl  <= c_d;
      cmd_byte  <= b_d;
    end
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic             msg_rev,
  input  logic             msg_nostart,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic             abort_req,
  input  logic             ev_valid,
  input  logic [7:0]       ev_code,
  input  logic [7:0]       ev_rx_byte,
  input  logic [7:0]       tx_byte,
  output logic             tx_take,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic             cmd_valid,
  output logic             cmd_ctrl,
  output logic [7:0]       cmd_byte,
  output logic             done,
  output logic [1:0]       result
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_st_e          st_q, st_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             sent_q, sent_d, abt_q, abt_d, ten_q, ten_d;
  logic [1:0]       rc_q, rc_d, res_d;
  logic [7:0]       ctl_q, ctl_d, a1_q, a1_d, a2_q, a2_d;
  logic [7:0]       a1_w, a2_w, d_byte, c_byte;
  logic             issue, has_d, rx_v_d, done_d, tmr_rst, tmr_hit, do_stop;
  logic             wr_ack, rd_aack;

  i2c_seq_addr u_addr (
    .addr(msg_addr), .ten(msg_ten), .rd(msg_rd), .rev(msg_rev),
    .byte1(a1_w), .byte2(a2_w)
  );

  i2c_seq_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_rst), .run(st_q != ST_IDLE),
    .limit(tmo_cycles), .hit(tmr_hit)
  );

  i2c_seq_emit u_emit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .has_data(has_d),
    .data_byte(d_byte), .ctrl_byte(c_byte),
    .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl), .cmd_byte(cmd_byte)
  );

  always_comb begin
    st_d = st_q; left_d = left_q; sent_d = sent_q; abt_d = abt_q;
    rc_d = rc_q; ctl_d = ctl_q; a1_d = a1_q; a2_d = a2_q; ten_d = ten_q;
    issue = 1'b0; has_d = 1'b0; d_byte = 8'h00; c_byte = 8'h00;
    tx_take = 1'b0; rx_v_d = 1'b0; done_d = 1'b0; res_d = rc_q;
    tmr_rst = 1'b0; do_stop = 1'b0;
    wr_ack  = (ev_code == SC_WA_ACK && !ten_q) || ev_code == SC_WA2_ACK ||
              ev_code == SC_WD_ACK;
    rd_aack = (ev_code == SC_RA_ACK && !ten_q) || ev_code == SC_RA2_ACK;

    if (go && st_q == ST_IDLE) begin
      // prepare the message and issue its first action
      left_d = msg_len; sent_d = 1'b0; abt_d = 1'b0; rc_d = RES_OK;
      ctl_d = CB_INIT; a1_d = a1_w; a2_d = a2_w; ten_d = msg_ten;
      tmr_rst = 1'b1; issue = 1'b1;
      if (msg_nostart && msg_rd) begin
        c_byte = CB_INIT; st_d = ST_RXDAT;
      end else if (msg_nostart) begin
        has_d = 1'b1; d_byte = tx_byte; tx_take = 1'b1; c_byte = CB_INIT;
        sent_d = 1'b1; st_d = ST_TXACK;
        if (msg_len != '0) left_d = msg_len - ONE;
      end else begin
        c_byte = CB_INIT | CB_START; st_d = ST_START;
      end
    end else if (ev_valid) begin
      issue = 1'b1;
      c_byte = ctl_q;
      if (st_q == ST_IDLE) begin
        do_stop = 1'b1;
      end else if (ev_code == SC_START || ev_code == SC_RSTART) begin
        has_d = 1'b1; d_byte = a1_q; st_d = ST_ADR1;
      end else if ((ev_code == SC_WA_ACK || ev_code == SC_RA_ACK) && ten_q) begin
        has_d = 1'b1; d_byte = a2_q; st_d = ST_ADR2;
      end else if (wr_ack) begin
        if (left_q == '0 || (abt_q && sent_q)) begin
          do_stop = 1'b1; done_d = 1'b1;
        end else begin
          has_d = 1'b1; d_byte = tx_byte; tx_take = 1'b1;
          left_d = left_q - ONE; sent_d = 1'b1; st_d = ST_TXACK;
        end
      end else if (rd_aack || ev_code == SC_RD_ACK) begin
        if (rd_aack && left_q == '0) begin
          do_stop = 1'b1; done_d = 1'b1;
        end else begin
          if (!rd_aack) begin
            rx_v_d = 1'b1; left_d = left_q - ONE;
          end
          if (left_d == ONE || abt_q) ctl_d = ctl_q & ~CB_ACK;
          c_byte = ctl_d; st_d = ST_RXDAT;
        end
      end else if (ev_code == SC_RD_NAK) begin
        rx_v_d = 1'b1; do_stop = 1'b1; done_d = 1'b1;
      end else if (ev_code == SC_WA_NAK || ev_code == SC_WD_NAK ||
                   ev_code == SC_RA_NAK) begin
        do_stop = 1'b1; done_d = 1'b1; rc_d = RES_NODEV; res_d = RES_NODEV;
      end else begin
        do_stop = 1'b1; done_d = 1'b1; rc_d = RES_IOERR; res_d = RES_IOERR;
      end
      if (do_stop) begin
        ctl_d = ctl_d & ~CB_INTEN; c_byte = ctl_d | CB_STOP; st_d = ST_IDLE;
      end
    end else if (st_q != ST_IDLE && tmr_hit) begin
      if (!abt_q) begin
        abt_d = 1'b1; rc_d = RES_TMO; tmr_rst = 1'b1;
      end else begin
        st_d = ST_IDLE; done_d = 1'b1; res_d = RES_TMO; rc_d = RES_TMO;
      end
    end else if (st_q != ST_IDLE && abort_req && !abt_q) begin
      abt_d = 1'b1; tmr_rst = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; left_q <= '0; sent_q <= 1'b0; abt_q <= 1'b0;
      rc_q <= RES_OK; ctl_q <= CB_INIT; a1_q <= 8'h00; a2_q <= 8'h00;
      ten_q <= 1'b0; rx_valid <= 1'b0; rx_byte <= 8'h00;
      done <= 1'b0; result <= RES_OK;
    end else begin
      st_q <= st_d; left_q <= left_d; sent_q <= sent_d; abt_q <= abt_d;
      rc_q <= rc_d; ctl_q <= ctl_d; a1_q <= a1_d; a2_q <= a2_d;
      ten_q <= ten_d; rx_valid <= rx_v_d; done <= done_d;
      if (rx_v_d) rx_byte <= ev_rx_byte;
      if (done_d) result <= res_d;
    end
  end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ctrl,
  input logic [7:0] cmd_byte,
  input logic       done,
  input logic [1:0] result,
  input logic       rx_valid
);
  p_en_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ctrl |-> cmd_byte[6]);

  p_stop_no_inten_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ctrl && cmd_byte[4] |-> !cmd_byte[7]);

  p_data_then_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ctrl |=> cmd_valid && cmd_ctrl);

  p_done_with_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && cmd_valid |-> cmd_ctrl && cmd_byte[4]);

  p_silent_done_tmo_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cmd_valid |-> result == 2'd3);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rx_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(cmd_valid && !cmd_ctrl));
endmodule

bind i2c_msg_seq i2c_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
  .cmd_byte(cmd_byte), .done(done), .result(result), .rx_valid(rx_valid)
);

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, msg_ten = 1'b0, msg_rd = 1'b0, msg_rev = 1'b0, msg_nostart = 1'b0;
  logic [9:0] msg_addr = '0;
  logic [7:0] msg_len = '0;
  logic [15:0] tmo_cycles = 16'd1000;
  logic abort_req = 1'b0, ev_valid = 1'b0;
  logic [7:0] ev_code = '0, ev_rx_byte = '0;
  logic [7:0] tx_byte;
  logic tx_take, rx_valid, cmd_valid, cmd_ctrl, done;
  logic [7:0] rx_byte, cmd_byte;
  logic [1:0] result;

  logic [7:0] txmem [64];
  logic [5:0] take_cnt = '0;
  int wr_ptr = 0;
  int n_chk = 0, n_fail = 0;

  logic [8:0] cmd_q[$];  string cmd_t[$];
  logic [7:0] rx_q[$];   string rx_t[$];
  logic [1:0] done_q[$]; string done_t[$];

  always #2.5 clk = ~clk;

  i2c_msg_seq i_i2c_msg_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .msg_addr(msg_addr), .msg_ten(msg_ten),
    .msg_rd(msg_rd), .msg_rev(msg_rev), .msg_nostart(msg_nostart), .msg_len(msg_len),
    .tmo_cycles(tmo_cycles), .abort_req(abort_req), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_rx_byte(ev_rx_byte), .tx_byte(tx_byte), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
    .cmd_byte(cmd_byte), .done(done), .result(result)
  );

  assign tx_byte = txmem[take_cnt];
  always @(posedge clk) if (tx_take) take_cnt <= take_cnt + 6'd1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      if (cmd_q.size() == 0) chk(0, "R9 unexpected command", {cmd_ctrl, cmd_byte}, 0);
      else begin
        logic [8:0] e; string t;
        e = cmd_q.pop_front(); t = cmd_t.pop_front();
        chk({cmd_ctrl, cmd_byte} == e, t, {cmd_ctrl, cmd_byte}, e);
      end
    end
    if (rx_valid) begin
      if (rx_q.size() == 0) chk(0, "R5 unexpected rx", rx_byte, 0);
      else begin
        logic [7:0] e; string t;
        e = rx_q.pop_front(); t = rx_t.pop_front();
        chk(rx_byte == e, t, rx_byte, e);
      end
    end
    if (done) begin
      if (done_q.size() == 0) chk(0, "R11 unexpected done", result, 0);
      else begin
        logic [1:0] e; string t;
        e = done_q.pop_front(); t = done_t.pop_front();
        chk(result == e, t, result, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic xc(input bit c, input logic [7:0] b, input string t);
    cmd_q.push_back({c, b}); cmd_t.push_back(t);
  endtask
  task automatic xr(input logic [7:0] b, input string t);
    rx_q.push_back(b); rx_t.push_back(t);
  endtask
  task automatic xd(input logic [1:0] r, input string t);
    done_q.push_back(r); done_t.push_back(t);
  endtask
  task automatic txput(input logic [7:0] b);
    txmem[wr_ptr[5:0]] = b; wr_ptr++;
  endtask
  task automatic launch(input logic [9:0] a, input bit ten, input bit rd, input bit rev,
                        input bit ns, input logic [7:0] len);
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_rev = rev; msg_nostart = ns;
    msg_len = len; go = 1'b1;
    tick(1); go = 1'b0; tick(4);
  endtask
  task automatic ev(input logic [7:0] code, input logic [7:0] rxb);
    ev_valid = 1'b1; ev_code = code; ev_rx_byte = rxb;
    tick(1); ev_valid = 1'b0; tick(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) txmem[i] = 8'h00;
    tick(3);
    @(negedge clk);
    chk(!cmd_valid && !done && !rx_valid && !tx_take, "R3 reset idle",
        {cmd_valid, done, rx_valid, tx_take}, 0);
    rst_n = 1'b1; tick(2);

    // 7-bit write, two bytes
    txput(8'hAA); txput(8'hBB);
    xc(1, 8'hE4, "R3 start ctrl");  launch(10'h050, 0, 0, 0, 0, 8'd2);
    xc(0, 8'hA0, "R1 addr byte"); xc(1, 8'hC4, "R9 ctrl after addr"); ev(8'h08, 0);
    xc(0, 8'hAA, "R4 data 1"); xc(1, 8'hC4, "R4 ctrl"); ev(8'h18, 0);
    xc(0, 8'hBB, "R4 data 2"); xc(1, 8'hC4, "R4 ctrl"); ev(8'h28, 0);
    xc(1, 8'h54, "R4 stop"); xd(0, "R4 result ok"); ev(8'h28, 0);

    // 7-bit read, two bytes
    xc(1, 8'hE4, "R3 start ctrl");  launch(10'h021, 0, 1, 0, 0, 8'd2);
    xc(0, 8'h43, "R1 read addr byte"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h10, 0);
    xc(1, 8'hC4, "R5 continue"); ev(8'h40, 0);
    xr(8'h11, "R5 rx byte"); xc(1, 8'hC0, "R6 ack cleared"); ev(8'h50, 8'h11);
    xr(8'h22, "R6 last rx"); xc(1, 8'h50, "R6 stop"); xd(0, "R6 result ok"); ev(8'h58, 8'h22);

    // 10-bit write, one byte
    txput(8'h5C);
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h2A5, 1, 0, 0, 0, 8'd1);
    xc(0, 8'hF4, "R2 first addr"); xc(1, 8'hC4, "R2 ctrl"); ev(8'h08, 0);
    xc(0, 8'hA5, "R2 second addr"); xc(1, 8'hC4, "R2 ctrl"); ev(8'h18, 0);
    xc(0, 8'h5C, "R4 data"); xc(1, 8'hC4, "R4 ctrl"); ev(8'hD0, 0);
    xc(1, 8'h54, "R4 stop"); xd(0, "R4 result"); ev(8'h28, 0);

    // reverse-direction write, no device
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h050, 0, 0, 1, 0, 8'd1);
    xc(0, 8'hA1, "R1 reversed dir"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xc(1, 8'h54, "R7 stop"); xd(1, "R7 no device"); ev(8'h20, 0);

    // zero-length read
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h033, 0, 1, 0, 0, 8'd0);
    xc(0, 8'h67, "R1 addr"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xc(1, 8'h54, "R5 zero-length stop"); xd(0, "R5 result"); ev(8'h40, 0);

    // unexpected status
    txput(8'h99);
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h050, 0, 0, 0, 0, 8'd2);
    xc(0, 8'hA0, "R1 addr"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xc(1, 8'h54, "R8 stop"); xd(2, "R8 io error"); ev(8'h38, 0);

    // stray event while idle
    xc(1, 8'h54, "R11 idle stop"); ev(8'h08, 0);

    // no-start write
    txput(8'h01); txput(8'h02);
    // first byte 0x99 was never taken; realign source
    xc(0, 8'h99, "R10 first data at once"); xc(1, 8'hC4, "R10 ctrl");
    launch(10'h000, 0, 0, 0, 1, 8'd2);
    xc(0, 8'h01, "R10 next data"); xc(1, 8'hC4, "R10 ctrl"); ev(8'h28, 0);
    xc(1, 8'h54, "R10 stop"); xd(0, "R10 result"); ev(8'h28, 0);

    // no-start read
    xc(1, 8'hC4, "R10 read continue"); launch(10'h000, 0, 1, 0, 1, 8'd1);
    xr(8'h77, "R10 rx"); xc(1, 8'h54, "R10 stop"); xd(0, "R10 result"); ev(8'h58, 8'h77);

    // timeout abort after one data byte
    tmo_cycles = 16'd30;
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h010, 0, 0, 0, 0, 8'd3);
    xc(0, 8'h20, "R1 addr"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xc(0, 8'h02, "R12 data"); xc(1, 8'hC4, "R12 ctrl"); ev(8'h18, 0);
    tick(25);
    xc(1, 8'h54, "R12 abort stop"); xd(3, "R12 timeout result"); ev(8'h28, 0);

    // abort request on a read
    tmo_cycles = 16'd1000;
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h021, 0, 1, 0, 0, 8'd3);
    xc(0, 8'h43, "R1 addr"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xc(1, 8'hC4, "R5 continue"); ev(8'h40, 0);
    abort_req = 1'b1; tick(1); abort_req = 1'b0; tick(2);
    xr(8'h31, "R12 rx"); xc(1, 8'hC0, "R12 abort clears ack"); ev(8'h50, 8'h31);
    xr(8'h32, "R6 rx"); xc(1, 8'h50, "R6 stop"); xd(0, "R12 abort result"); ev(8'h58, 8'h32);

    // bus lock: two windows expire
    tmo_cycles = 16'd30;
    xc(1, 8'hE4, "R3 start ctrl"); launch(10'h050, 0, 0, 0, 0, 8'd1);
    xc(0, 8'hA0, "R1 addr"); xc(1, 8'hC4, "R9 ctrl"); ev(8'h08, 0);
    xd(3, "R13 forced idle"); tick(80);
    xc(1, 8'h54, "R13 idle after lock"); ev(8'h18, 0);

    tick(5);
    chk(cmd_q.size() == 0, "R9 pending commands", cmd_q.size(), 0);
    chk(rx_q.size() == 0, "R5 pending rx", rx_q.size(), 0);
    chk(done_q.size() == 0, "R13 pending done", done_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule